// File: doc/BRIEF.md
# Fine-Adjust PTP Time-of-Day Clock

This block keeps a seconds and binary-subseconds time of day for precision-time hardware. A fractional addend accumulator runs on the system clock. Each carry out of that accumulator adds a programmable increment to a 31-bit subseconds counter. When the subseconds counter passes 2^31 it wraps and carries one into a 32-bit seconds counter. Software trims the clock rate by changing the addend, so the time can follow a remote master without a tunable oscillator.

Software uses a small synchronous register write port and a combinational read port. It stages the addend, the increment, the update values and a target time. It then issues one-cycle command bits. An addend reload moves the staged addend into the running accumulator. A time initialize loads the counters directly. A time adjust adds or subtracts a sign-magnitude correction. Two outputs are derived from the running time. One is a square wave at 2^n Hz, taken from a binary tap of the subseconds counter. The other is a one-cycle trigger pulse, raised once the time reaches or passes an armed target.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset the seconds and subseconds counters, the accumulator, the active addend, every command and arm bit, the run bit, the rate select, `pps_out` and `trig_out` are all zero.
- R2: On every clock with the run bit set, the 32-bit accumulator adds the active addend. Only a carry out of bit 31 of that sum produces a time tick. Starting from accumulator value a, k clocks produce floor((a + k*A) / 2^32) ticks.
- R3: Each tick adds the increment register (address 2, bits 7:0) to the subseconds counter.
- R4: When a tick takes the subseconds counter to 2^31 or beyond, the counter wraps modulo 2^31 and the seconds counter increases by one.
- R5: A write to the staged addend (address 1) leaves the running rate unchanged. Setting control bit 1 copies the staged value into the active addend, which reads back at address 7, on the following clock. Bit 1 reads as 1 for exactly that one clock and then clears itself.
- R6: Setting control bit 2 loads seconds from address 3 and subseconds from bits 30:0 of address 4 on the following clock. The bit reads as 1 for one clock and then clears itself.
- R7: When bit 31 of address 4 is clear, setting control bit 3 adds {address 3, address 4 bits 30:0} to the current time on the following clock. A subseconds overflow carries into seconds, and the bit clears itself.
- R8: When bit 31 of address 4 is set, control bit 3 subtracts that value instead. A subseconds underflow borrows one from seconds.
- R9: `pps_out` equals subseconds bit (30 - n), where n is control bits 11:8, clamped to the highest available tap. Rate 0 gives a 1 Hz wave and rate n gives a 2^n Hz wave, all aligned to second boundaries.
- R10: Control bit 4 arms the trigger. Target seconds are at address 5 and target subseconds at address 6. One clock after an armed check finds the time at or past the target, `trig_out` is high for one clock and the arm bit clears. A zero target fires on the first clock after arming.
- R11: With the run bit (control bit 0) clear and no time command pending, both counters hold their values.
- R12: Control bits 1 and 3 set in the same write are both carried out on the same following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| tod_sec | output | 32 | Seconds counter |
| tod_subsec | output | 31 | Binary subseconds counter |
| pps_out | output | 1 | Square wave at the selected power-of-two rate |
| trig_out | output | 1 | One-cycle target-time pulse |

## Verification
A write is captured at one rising edge. A command bit therefore reads back as 1 straight after that edge, and its effect on the counters or on the active addend appears one clock later. The bench samples at the falling edge between those two points, so it sees both the pending bit and the result. `pps_out` and the read port are combinational from registers and are checked in the same half-cycle that sets them up. `trig_out` rises one clock after the clock on which the time first meets the target. A run segment bracketed by two control writes covers N+1 accumulator edges for N idle cycles. The bench's accumulator model counts carries over exactly that many edges.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] RA_ADDEND  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_INCR    = 3'd2;
  localparam logic [ADDR_W-1:0] RA_UPD_SEC = 3'd3;
  localparam logic [ADDR_W-1:0] RA_UPD_SUB = 3'd4;
  localparam logic [ADDR_W-1:0] RA_TGT_SEC = 3'd5;
  localparam logic [ADDR_W-1:0] RA_TGT_SUB = 3'd6;
  localparam logic [ADDR_W-1:0] RA_ACT_ADD = 3'd7;

  localparam int CB_RUN    = 0;
  localparam int CB_ADD_LD = 1;
  localparam int CB_T_INIT = 2;
  localparam int CB_T_ADJ  = 3;
  localparam int CB_ARM    = 4;
  localparam int CB_SEL_LO = 8;

  typedef struct packed {
    logic add_ld;
    logic t_init;
    logic t_adj;
  } cmd_t;
endpackage

// File: rtl/ptp_reg_file.sv
module ptp_reg_file import ptp_time_pkg::*; #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fire_i,
  output logic              run_o,
  output logic [ACC_W-1:0]  addend_o,
  output logic [INC_W-1:0]  inc_o,
  output logic [SEC_W-1:0]  upd_sec_o,
  output logic [SUB_W-1:0]  upd_mag_o,
  output logic              upd_neg_o,
  output logic [SEC_W-1:0]  tgt_sec_o,
  output logic [SUB_W-1:0]  tgt_sub_o,
  output logic [SEL_W-1:0]  sel_o,
  output cmd_t              cmd_o,
  output logic              arm_o
);
  logic             ctrl_wr;
  logic             run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  cmd_t             cmd_q, cmd_d;
  logic             arm_q, arm_d;
  logic [ACC_W-1:0] add_sh_q, add_sh_d, add_act_q, add_act_d;
  logic [INC_W-1:0] inc_q, inc_d;
  logic [SEC_W-1:0] usec_q, usec_d, tsec_q, tsec_d;
  logic [SUB_W-1:0] umag_q, umag_d, tsub_q, tsub_d;
  logic             uneg_q, uneg_d;

  assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);

  always_comb begin
    run_d        = run_q;
    sel_d        = sel_q;
    cmd_d.add_ld = ctrl_wr && wr_data[CB_ADD_LD];
    cmd_d.t_init = ctrl_wr && wr_data[CB_T_INIT];
    cmd_d.t_adj  = ctrl_wr && wr_data[CB_T_ADJ];
    arm_d        = (arm_q && !fire_i) || (ctrl_wr && wr_data[CB_ARM]);
    add_sh_d     = add_sh_q;
    inc_d        = inc_q;
    usec_d       = usec_q;
    umag_d       = umag_q;
    uneg_d       = uneg_q;
    tsec_d       = tsec_q;
    tsub_d       = tsub_q;
    if (ctrl_wr) begin
      run_d = wr_data[CB_RUN];
      sel_d = wr_data[CB_SEL_LO +: SEL_W];
    end
    if (wr_en) begin
      case (wr_addr)
        RA_ADDEND:  add_sh_d = wr_data[ACC_W-1:0];
        RA_INCR:    inc_d    = wr_data[INC_W-1:0];
        RA_UPD_SEC: usec_d   = wr_data[SEC_W-1:0];
        RA_UPD_SUB: begin
          umag_d = wr_data[SUB_W-1:0];
          uneg_d = wr_data[DATA_W-1];
        end
        RA_TGT_SEC: tsec_d   = wr_data[SEC_W-1:0];
        RA_TGT_SUB: tsub_d   = wr_data[SUB_W-1:0];
        default: ;
      endcase
    end
    add_act_d = cmd_q.add_ld ? add_sh_q : add_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      sel_q     <= '0;
      cmd_q     <= '0;
      arm_q     <= 1'b0;
      add_sh_q  <= '0;
      add_act_q <= '0;
      inc_q     <= '0;
      usec_q    <= '0;
      umag_q    <= '0;
      uneg_q    <= 1'b0;
      tsec_q    <= '0;
      tsub_q    <= '0;
    end else begin
      run_q     <= run_d;
      sel_q     <= sel_d;
      cmd_q     <= cmd_d;
      arm_q     <= arm_d;
      add_sh_q  <= add_sh_d;
      add_act_q <= add_act_d;
      inc_q     <= inc_d;
      usec_q    <= usec_d;
      umag_q    <= umag_d;
      uneg_q    <= uneg_d;
      tsec_q    <= tsec_d;
      tsub_q    <= tsub_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[CB_RUN]              = run_q;
        rd_data[CB_ADD_LD]           = cmd_q.add_ld;
        rd_data[CB_T_INIT]           = cmd_q.t_init;
        rd_data[CB_T_ADJ]            = cmd_q.t_adj;
        rd_data[CB_ARM]              = arm_q;
        rd_data[CB_SEL_LO +: SEL_W]  = sel_q;
      end
      RA_ADDEND:  rd_data[ACC_W-1:0] = add_sh_q;
      RA_INCR:    rd_data[INC_W-1:0] = inc_q;
      RA_UPD_SEC: rd_data[SEC_W-1:0] = usec_q;
      RA_UPD_SUB: begin
        rd_data[SUB_W-1:0]  = umag_q;
        rd_data[DATA_W-1]   = uneg_q;
      end
      RA_TGT_SEC: rd_data[SEC_W-1:0] = tsec_q;
      RA_TGT_SUB: rd_data[SUB_W-1:0] = tsub_q;
      RA_ACT_ADD: rd_data[ACC_W-1:0] = add_act_q;
      default: ;
    endcase
  end

  assign run_o     = run_q;
  assign addend_o  = add_act_q;
  assign inc_o     = inc_q;
  assign upd_sec_o = usec_q;
  assign upd_mag_o = umag_q;
  assign upd_neg_o = uneg_q;
  assign tgt_sec_o = tsec_q;
  assign tgt_sub_o = tsub_q;
  assign sel_o     = sel_q;
  assign cmd_o     = cmd_q;
  assign arm_o     = arm_q;

  // The staged addend only reaches the accumulator through the reload command
  assert_addend_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.add_ld |=> (add_act_q == $past(add_sh_q)));
  assert_addend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q.add_ld |=> $stable(add_act_q));
endmodule

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, addend_i};
    acc_d  = run_i ? sum[ACC_W-1:0] : acc_q;
    tick_o = run_i && sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // A carry leaves a residue below the addend; a non-carry step leaves one at or above it
  assert_carry_residue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (acc_q < $past(addend_i)));
  assert_nocarry_residue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_o) |=> (acc_q >= $past(addend_i)));
endmodule

// File: rtl/ptp_tod.sv
module ptp_tod #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             init_i,
  input  logic             adj_i,
  input  logic [SEC_W-1:0] upd_sec_i,
  input  logic [SUB_W-1:0] upd_mag_i,
  input  logic             upd_neg_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int TW = SEC_W + SUB_W;

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SUB_W:0]   step, sum_a, diff_s;

  always_comb begin
    step   = {1'b0, sub_q} + {{(SUB_W+1-INC_W){1'b0}}, inc_i};
    sum_a  = {1'b0, sub_q} + {1'b0, upd_mag_i};
    diff_s = {1'b0, sub_q} - {1'b0, upd_mag_i};
    sec_d  = sec_q;
    sub_d  = sub_q;
    if (init_i) begin
      sec_d = upd_sec_i;
      sub_d = upd_mag_i;
    end else if (adj_i) begin
      if (upd_neg_i) begin
        sub_d = diff_s[SUB_W-1:0];
        sec_d = sec_q - upd_sec_i - SEC_W'(diff_s[SUB_W]);
      end else begin
        sub_d = sum_a[SUB_W-1:0];
        sec_d = sec_q + upd_sec_i + SEC_W'(sum_a[SUB_W]);
      end
    end else if (tick_i) begin
      sub_d = step[SUB_W-1:0];
      sec_d = sec_q + SEC_W'(step[SUB_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;

  // Joined as one number, the time grows by exactly the increment per tick (covers the wrap of R4)
  assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !init_i && !adj_i) |=>
      ({sec_q, sub_q} == $past({sec_q, sub_q}) + TW'($past(inc_i))));
  assert_init_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (sec_q == $past(upd_sec_i)) && (sub_q == $past(upd_mag_i)));
  assert_update_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_i && !init_i && !upd_neg_i) |=>
      ({sec_q, sub_q} == $past({sec_q, sub_q}) + $past({upd_sec_i, upd_mag_i})));
  assert_update_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_i && !init_i && upd_neg_i) |=>
      ({sec_q, sub_q} == $past({sec_q, sub_q}) - $past({upd_sec_i, upd_mag_i})));
endmodule

// File: rtl/ptp_pulse_gen.sv
module ptp_pulse_gen #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             arm_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [SUB_W-1:0] tgt_sub_i,
  output logic             pps_o,
  output logic             fire_o,
  output logic             trig_o
);
  localparam int SEL_TOP = (1 << SEL_W) - 1;
  localparam int SEL_LIM = ((SUB_W - 1) < SEL_TOP) ? (SUB_W - 1) : SEL_TOP;

  logic [SEL_LIM:0] taps;
  logic [SEL_W-1:0] sel_c;
  logic             reached;
  logic             trig_q, trig_d;

  for (genvar k = 0; k <= SEL_LIM; k++) begin : g_tap
    assign taps[k] = sub_i[SUB_W-1-k];
  end

  always_comb begin
    sel_c   = (int'(sel_i) > SEL_LIM) ? SEL_W'(SEL_LIM) : sel_i;
    pps_o   = taps[sel_c];
    reached = (sec_i > tgt_sec_i) || ((sec_i == tgt_sec_i) && (sub_i >= tgt_sub_i));
    fire_o  = arm_i && reached;
    trig_d  = fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  assert_fire_reached_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past({sec_i, sub_i} >= {tgt_sec_i, tgt_sub_i}));
  assert_fire_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(arm_i));
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock import ptp_time_pkg::*; #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [SUB_W-1:0]  tod_subsec,
  output logic              pps_out,
  output logic              trig_out
);
  logic             run;
  logic [ACC_W-1:0] addend;
  logic [INC_W-1:0] inc;
  logic [SEC_W-1:0] upd_sec, tgt_sec;
  logic [SUB_W-1:0] upd_mag, tgt_sub;
  logic             upd_neg;
  logic [SEL_W-1:0] sel;
  cmd_t             cmd;
  logic             arm, fire, tick;

  ptp_reg_file #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fire_i(fire), .run_o(run), .addend_o(addend),
    .inc_o(inc), .upd_sec_o(upd_sec), .upd_mag_o(upd_mag), .upd_neg_o(upd_neg),
    .tgt_sec_o(tgt_sec), .tgt_sub_o(tgt_sub), .sel_o(sel), .cmd_o(cmd), .arm_o(arm)
  );

  ptp_rate_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .run_i(run), .addend_i(addend), .tick_o(tick)
  );

  ptp_tod #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_tod (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .inc_i(inc), .init_i(cmd.t_init),
    .adj_i(cmd.t_adj), .upd_sec_i(upd_sec), .upd_mag_i(upd_mag), .upd_neg_i(upd_neg),
    .sec_o(tod_sec), .sub_o(tod_subsec)
  );

  ptp_pulse_gen #(.SEC_W(SEC_W), .SUB_W(SUB_W), .SEL_W(SEL_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .sec_i(tod_sec), .sub_i(tod_subsec), .sel_i(sel),
    .arm_i(arm), .tgt_sec_i(tgt_sec), .tgt_sub_i(tgt_sub), .pps_o(pps_out),
    .fire_o(fire), .trig_o(trig_out)
  );

  assert_hold_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd.t_init && !cmd.t_adj) |=> ($stable(tod_sec) && $stable(tod_subsec)));
endmodule

// File: tb/test_ptp_fine_clock.sv
module test_ptp_fine_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] tod_sec;
  logic [30:0] tod_subsec;
  logic        pps_out, trig_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_acc = '0, m_add = '0, m_sec = '0;
  logic [30:0] m_sub = '0;
  logic [7:0]  m_inc = '0;
  logic [3:0]  m_sel = '0;

  always #4 clk = ~clk;

  ptp_fine_clock i_ptp_fine_clock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_subsec(tod_subsec),
    .pps_out(pps_out), .trig_out(trig_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] ctrl(input logic [7:0] bits);
    return {20'd0, m_sel, 3'd0, bits[4:0]};
  endfunction

  task automatic check_time(input string req);
    check(req, {1'b0, tod_sec, tod_subsec}, {1'b0, m_sec, m_sub});
  endtask

  task automatic run_for(input int n);
    int ticks = 0;
    logic [63:0] tot;
    wr(3'd0, ctrl(8'h01));
    repeat (n) @(negedge clk);
    wr(3'd0, ctrl(8'h00));
    for (int e = 0; e < n + 1; e++) begin
      logic [32:0] s;
      s = {1'b0, m_acc} + {1'b0, m_add};
      m_acc = s[31:0];
      if (s[32]) ticks++;
    end
    tot = {33'd0, m_sub} + 64'(ticks) * 64'(m_inc);
    m_sec = m_sec + tot[62:31];
    m_sub = tot[30:0];
  endtask

  task automatic load_addend(input logic [31:0] a);
    logic [31:0] r;
    wr(3'd1, a);
    wr(3'd0, ctrl(8'h02));
    rd(3'd0, r);
    check("R5 reload bit pending", 64'(r[1]), 64'd1);
    @(negedge clk);
    rd(3'd0, r);
    check("R5 reload bit cleared", 64'(r[1]), 64'd0);
    rd(3'd7, r);
    check("R5 active addend", 64'(r), 64'(a));
    m_add = a;
  endtask

  task automatic set_time(input logic [31:0] s, input logic [30:0] ss);
    logic [31:0] r;
    wr(3'd3, s);
    wr(3'd4, {1'b0, ss});
    wr(3'd0, ctrl(8'h04));
    rd(3'd0, r);
    check("R6 init bit pending", 64'(r[2]), 64'd1);
    @(negedge clk);
    rd(3'd0, r);
    check("R6 init bit cleared", 64'(r[2]), 64'd0);
    m_sec = s; m_sub = ss;
  endtask

  task automatic adjust(input logic neg, input logic [31:0] s, input logic [30:0] mag);
    logic [62:0] t;
    logic [31:0] r;
    wr(3'd3, s);
    wr(3'd4, {neg, mag});
    wr(3'd0, ctrl(8'h08));
    @(negedge clk);
    rd(3'd0, r);
    check("R7 adjust bit cleared", 64'(r[3]), 64'd0);
    t = neg ? ({m_sec, m_sub} - {s, mag}) : ({m_sec, m_sub} + {s, mag});
    m_sec = t[62:31]; m_sub = t[30:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] adds [5];
    int          lens [5];
    logic [30:0] subs [6];
    adds[0] = 32'h8000_0000; adds[1] = 32'hFFFF_FFFF; adds[2] = 32'h1234_5678;
    adds[3] = 32'hFBB8_3DEF; adds[4] = 32'h0000_0001;
    lens[0] = 11; lens[1] = 23; lens[2] = 40; lens[3] = 7; lens[4] = 64;
    subs[0] = 31'h0; subs[1] = 31'h4000_0000; subs[2] = 31'h2AAA_AAAA;
    subs[3] = 31'h5555_5555; subs[4] = 31'h7FFF_FFFF; subs[5] = 31'h1234_5678;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_time("R1 time after reset");
    check("R1 pps after reset", 64'(pps_out), 64'd0);
    check("R1 trig after reset", 64'(trig_out), 64'd0);
    rd(3'd0, r); check("R1 control after reset", 64'(r), 64'd0);
    rd(3'd7, r); check("R1 active addend after reset", 64'(r), 64'd0);

    // R5: staged addend has no effect without the reload bit
    wr(3'd2, 32'd13); m_inc = 8'd13;
    wr(3'd1, 32'h8000_0000);
    rd(3'd7, r); check("R5 active addend unchanged", 64'(r), 64'd0);
    run_for(10);
    check_time("R5 no ticks from staged addend");

    // R2 R3: rate sweep over several addends and run lengths
    for (int i = 0; i < 5; i++) begin
      load_addend(adds[i]);
      run_for(lens[i]);
      check_time("R2 R3 time after run segment");
    end

    // R4: wrap into seconds
    set_time(32'd7, 31'h7FFF_FFE2);
    check_time("R6 time loaded");
    load_addend(32'hFFFF_FFFF);
    run_for(5);
    check_time("R4 subsecond wrap");
    check("R4 seconds advanced", 64'(tod_sec), 64'd8);

    // R7 add with carry, R8 subtract with and without borrow
    adjust(1'b0, 32'd3, 31'h7FFF_FFF0);
    check_time("R7 add with carry");
    adjust(1'b1, 32'd1, 31'h7FFF_FFFF);
    check_time("R8 subtract with borrow");
    adjust(1'b1, 32'd2, 31'h0000_0001);
    check_time("R8 subtract without borrow");

    // R12: reload and adjust in one write
    wr(3'd1, 32'h4000_0000);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd5);
    wr(3'd0, ctrl(8'h0A));
    @(negedge clk);
    begin
      logic [62:0] t;
      t = {m_sec, m_sub} + {32'd1, 31'd5};
      m_sec = t[62:31]; m_sub = t[30:0];
    end
    m_add = 32'h4000_0000;
    check_time("R12 adjust applied");
    rd(3'd7, r); check("R12 addend applied", 64'(r), 64'h4000_0000);
    run_for(9);
    check_time("R12 new rate in effect");

    // R11: hold while stopped
    repeat (20) @(negedge clk);
    check_time("R11 hold while stopped");

    // R9: tap sweep
    for (int n = 0; n < 16; n++) begin
      m_sel = 4'(n);
      wr(3'd0, ctrl(8'h00));
      for (int j = 0; j < 6; j++) begin
        set_time(32'd1, subs[j]);
        check("R9 pps tap", 64'(pps_out), 64'(subs[j][30-n]));
      end
    end

    // R10: zero target fires on arming
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd0);
    wr(3'd0, ctrl(8'h10));
    check("R10 no pulse on arming edge", 64'(trig_out), 64'd0);
    @(negedge clk);
    check("R10 zero target fires", 64'(trig_out), 64'd1);
    @(negedge clk);
    check("R10 pulse one cycle", 64'(trig_out), 64'd0);
    rd(3'd0, r); check("R10 arm cleared", 64'(r[4]), 64'd0);

    // R10: future target reached by an adjust
    set_time(32'd3, 31'd99);
    wr(3'd5, 32'd3);
    wr(3'd6, 32'd100);
    wr(3'd0, ctrl(8'h10));
    repeat (3) @(negedge clk);
    check("R10 no pulse before target", 64'(trig_out), 64'd0);
    rd(3'd0, r); check("R10 still armed", 64'(r[4]), 64'd1);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd0, ctrl(8'h08));
    @(negedge clk);
    m_sub = 31'd100;
    check_time("R7 adjust to target");
    check("R10 pulse not yet", 64'(trig_out), 64'd0);
    @(negedge clk);
    check("R10 pulse at target", 64'(trig_out), 64'd1);
    @(negedge clk);
    check("R10 pulse ends", 64'(trig_out), 64'd0);

    // R10: target already passed
    wr(3'd5, 32'd2);
    wr(3'd6, 32'd5);
    wr(3'd0, ctrl(8'h10));
    @(negedge clk);
    check("R10 passed target fires", 64'(trig_out), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule